// File: doc/BRIEF.md
# Ping-pong receive buffer with address filter

This block is the receive half of a small Ethernet MAC. Frame bytes arrive one per cycle on a byte stream that marks the final byte. The block checks the six-byte destination address against a station address, or lets any group-addressed frame through. It stores each accepted frame into one of two receive buffers and then flags that buffer as full in its control word. When ping-pong operation is built in, the next frame goes to the other buffer. A frame is lost when its target buffer is still full. Frames that fail the address check are discarded.

Software reads the stored frames through a word-addressed slave port. It releases a buffer by writing its control word with the status bit cleared. No length register exists, so software reads the buffer to find the frame size. When a frame is stored, a one-cycle interrupt pulse is raised if both the buffer's own interrupt enable and the global enable are set.

The register window is 4*BUF_BYTES bytes, which is BUF_BYTES words. The lower half is the transmit region. Of it, only the global enable word at word BUF_WORDS-2 is implemented, and every other word there reads zero. Receive buffer 0 occupies the third quarter of the window and buffer 1 the last quarter. The top word of each receive quarter is that buffer's control word.

Top module: `ethrx_pingpong`

## Requirements
- R1: Bus reads return data one cycle after the address is applied. Word 2*BUF_WORDS+b*BUF_WORDS+w reads data word w of buffer b, and word 3*BUF_WORDS-1+b*BUF_WORDS reads control word b. Word BUF_WORDS-2 reads the global enable, and any other word of the lower half reads zero.
- R2: A frame is accepted when bit 7 of its first byte is 1, or when its six leading bytes equal station_mac, where byte k is compared with station_mac[47-8k -: 8]. Any other frame leaves the status bits, the interrupt and the buffer pointer unchanged.
- R3: A frame whose last byte comes before its sixth byte is discarded.
- R4: If the status bit (bit 0) of the selected buffer is 1 when a frame's first byte arrives, the frame is dropped. Nothing is written and the pointer does not move.
- R5: Byte n of a stored frame lands in data word n/4 at bits [31-8*(n%4) -: 8].
- R6: The cycle after the last byte of an accepted frame, that buffer's status bit reads 1.
- R7: rx_irq is high for exactly one cycle, the cycle after the last byte of an accepted frame. This happens only if bit 3 of that buffer's control word and bit 31 of the global enable are both 1.
- R8: With PINGPONG=1 the first frame after reset goes to buffer 0 and the buffer toggles after every stored frame. With PINGPONG=0 every frame targets buffer 0.
- R9: Bytes beyond index BUF_BYTES-5 are discarded, the control word is not overwritten, and the frame is still marked full.
- R10: A bus write to a control word or to the global enable stores all 32 bits as written. If the write coincides with the completion of a frame into that buffer, the status bit still ends up 1.
- R11: After reset both control words and the global enable read zero, rx_irq is low and buffer 0 is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | A frame byte is present this cycle |
| rx_data | input | 8 | Frame byte |
| rx_last | input | 1 | The present byte ends the frame |
| station_mac | input | 48 | Station address, first byte in bits 47:40 |
| bus_addr | input | $clog2(BUF_BYTES) | Word address into the register window |
| bus_wen | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the address |
| rx_irq | output | 1 | One-cycle receive interrupt pulse |

## Verification
The bench builds two copies with BUF_BYTES=64, one with ping-pong and one without. This puts the 60-byte storage limit and the 16-word buffers within a short run. Every frame length from 6 bytes to four past the limit is sent in turn and the stored words are compared byte by byte. A single-byte mismatch is tried at each of the six address positions, together with every too-short length. The same small window also makes it cheap to cover the drop on a full buffer, the single-buffer variant and a software write that lands on the completion cycle.

// File: rtl/ethrx_pkg.sv
package ethrx_pkg;

  localparam int unsigned HDR_BYTES = 6;
  localparam int unsigned S_BIT     = 0;
  localparam int unsigned I_BIT     = 3;
  localparam int unsigned GIE_BIT   = 31;

  typedef enum logic [1:0] {
    RD_ZERO = 2'd0,
    RD_REG  = 2'd1,
    RD_MEM  = 2'd2
  } rd_kind_e;

  // Address byte k of the station address, first byte in the top bits.
  function automatic logic [7:0] station_byte(input logic [47:0] mac, input logic [2:0] k);
    logic [7:0] b;
    case (k)
      3'd0:    b = mac[47:40];
      3'd1:    b = mac[39:32];
      3'd2:    b = mac[31:24];
      3'd3:    b = mac[23:16];
      3'd4:    b = mac[15:8];
      3'd5:    b = mac[7:0];
      default: b = 8'h00;
    endcase
    return b;
  endfunction

  // The first byte of a word sits in the most significant lane.
  function automatic logic [1:0] lane_of(input logic [1:0] byte_lo);
    return 2'd3 - byte_lo;
  endfunction

  function automatic logic is_group(input logic [7:0] first_byte);
    return first_byte[7];
  endfunction

endpackage

// File: rtl/ethrx_addr_filter.sv
module ethrx_addr_filter
  import ethrx_pkg::*;
#(
  parameter int unsigned CAP_BYTES = 2044,
  parameter int unsigned CW        = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  input  logic          in_last,
  input  logic [47:0]   station,
  input  logic          blocked,
  output logic          sof,
  output logic          wr_en,
  output logic [CW-1:0] wr_idx,
  output logic          commit,
  output logic          reject,
  output logic          drop,
  output logic          drop_now
);

  localparam logic [CW-1:0] CAP_IDX  = CW'(CAP_BYTES);
  localparam logic [CW-1:0] HDR_N    = CW'(HDR_BYTES);
  localparam logic [CW-1:0] HDR_LAST = CW'(HDR_BYTES - 1);

  logic          in_frame_q;
  logic [CW-1:0] cnt_q;
  logic          match_q, group_q, drop_q, acc_q;

  logic [CW-1:0] idx;
  logic          hdr, match_now, group_now, acc_now;

  always_comb begin
    idx       = in_frame_q ? cnt_q : '0;
    sof       = in_valid && !in_frame_q;
    drop_now  = sof ? blocked : drop_q;
    hdr       = idx < HDR_N;
    group_now = (idx == '0) ? is_group(in_data) : group_q;
    match_now = ((idx == '0) ? 1'b1 : match_q) &&
                (!hdr || (in_data == station_byte(station, idx[2:0])));
    acc_now   = hdr ? ((idx == HDR_LAST) && !drop_now && (group_now || match_now))
                    : acc_q;
    wr_en     = in_valid && !drop_now && (idx < CAP_IDX) && (hdr || acc_q);
    wr_idx    = idx;
    commit    = in_valid && in_last && acc_now;
    reject    = in_valid && in_last && !drop_now && !acc_now;
    drop      = in_valid && in_last && drop_now;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      cnt_q      <= '0;
      match_q    <= 1'b0;
      group_q    <= 1'b0;
      drop_q     <= 1'b0;
      acc_q      <= 1'b0;
    end else if (in_valid) begin
      in_frame_q <= !in_last;
      if (in_last)             cnt_q <= '0;
      else if (idx == CAP_IDX) cnt_q <= idx;
      else                     cnt_q <= idx + 1'b1;
      match_q <= match_now;
      group_q <= group_now;
      drop_q  <= drop_now;
      acc_q   <= acc_now;
    end
  end

endmodule

// File: rtl/ethrx_buf_mem.sv
module ethrx_buf_mem #(
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned MW    = 10
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [MW-1:0] wr_word,
  input  logic [1:0]    wr_lane,
  input  logic [7:0]    wr_byte,
  input  logic [MW-1:0] rd_word,
  output logic [31:0]   rd_data
);

  for (genvar l = 0; l < 4; l++) begin : g_lane
    logic [7:0] lane_mem [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en && (wr_lane == 2'(l))) lane_mem[wr_word] <= wr_byte;
      rd_data[8*l +: 8] <= lane_mem[rd_word];
    end
  end

endmodule

// File: rtl/ethrx_ctrl_bank.sv
module ethrx_ctrl_bank
  import ethrx_pkg::*;
#(
  parameter bit PINGPONG = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       sw_wr_ctrl,
  input  logic             sw_wr_gie,
  input  logic [31:0]      wdata,
  input  logic             commit,
  output logic [1:0][31:0] ctrl,
  output logic [31:0]      gie,
  output logic             sel,
  output logic             irq
);

  for (genvar b = 0; b < 2; b++) begin : g_ctrl
    logic [31:0] word_q, word_nx;

    always_comb begin
      word_nx = sw_wr_ctrl[b] ? wdata : word_q;
      if (commit && (sel == 1'(b))) word_nx[S_BIT] = 1'b1;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) word_q <= '0;
      else        word_q <= word_nx;
    end

    assign ctrl[b] = word_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gie <= '0;
      irq <= 1'b0;
    end else begin
      if (sw_wr_gie) gie <= wdata;
      irq <= commit && ctrl[sel][I_BIT] && gie[GIE_BIT];
    end
  end

  if (PINGPONG) begin : g_pingpong
    logic sel_q;
    always_ff @(posedge clk) begin
      if (!rst_n)      sel_q <= 1'b0;
      else if (commit) sel_q <= ~sel_q;
    end
    assign sel = sel_q;
  end else begin : g_single
    assign sel = 1'b0;
  end

endmodule

// File: rtl/ethrx_pingpong.sv
module ethrx_pingpong
  import ethrx_pkg::*;
#(
  parameter int unsigned BUF_BYTES = 2048,
  parameter bit          PINGPONG  = 1'b1,
  localparam int unsigned AW       = $clog2(BUF_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  input  logic          rx_last,
  input  logic [47:0]   station_mac,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wen,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          rx_irq
);

  localparam int unsigned BUF_WORDS = BUF_BYTES / 4;
  localparam int unsigned OW        = AW - 2;
  localparam int unsigned MW        = AW - 1;
  localparam int unsigned CW        = AW;
  localparam int unsigned CAP       = BUF_BYTES - 4;

  // bus decode
  logic [1:0]    region;
  logic [OW-1:0] off;
  logic          is_rx, rbuf, is_ctrl, is_gie;
  logic [1:0]    sw_wr_ctrl;
  logic          sw_wr_gie;

  always_comb begin
    region     = bus_addr[AW-1:AW-2];
    off        = bus_addr[OW-1:0];
    is_rx      = region[1];
    rbuf       = region[0];
    is_ctrl    = (off == '1);
    is_gie     = (region == 2'd0) && (off == OW'(BUF_WORDS - 2));
    sw_wr_ctrl = '0;
    sw_wr_ctrl[rbuf] = bus_wen && is_rx && is_ctrl;
    sw_wr_gie  = bus_wen && is_gie;
  end

  // events brought out for the checker
  logic          ev_sof, ev_wr, ev_commit, ev_reject, ev_drop, drop_now;
  logic [CW-1:0] wr_idx;
  logic          sel;
  logic [1:0][31:0] ctrl;
  logic [31:0]   gie;
  logic [1:0]    s_bits;
  logic          blocked;

  assign s_bits  = {ctrl[1][S_BIT], ctrl[0][S_BIT]};
  assign blocked = s_bits[sel];

  ethrx_addr_filter #(.CAP_BYTES(CAP), .CW(CW)) u_filter (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (rx_valid),
    .in_data  (rx_data),
    .in_last  (rx_last),
    .station  (station_mac),
    .blocked  (blocked),
    .sof      (ev_sof),
    .wr_en    (ev_wr),
    .wr_idx   (wr_idx),
    .commit   (ev_commit),
    .reject   (ev_reject),
    .drop     (ev_drop),
    .drop_now (drop_now)
  );

  ethrx_ctrl_bank #(.PINGPONG(PINGPONG)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .sw_wr_ctrl (sw_wr_ctrl),
    .sw_wr_gie  (sw_wr_gie),
    .wdata      (bus_wdata),
    .commit     (ev_commit),
    .ctrl       (ctrl),
    .gie        (gie),
    .sel        (sel),
    .irq        (rx_irq)
  );

  logic [31:0] mem_q;

  ethrx_buf_mem #(.DEPTH(2 * BUF_WORDS), .MW(MW)) u_mem (
    .clk     (clk),
    .wr_en   (ev_wr),
    .wr_word ({sel, wr_idx[CW-1:2]}),
    .wr_lane (lane_of(wr_idx[1:0])),
    .wr_byte (rx_data),
    .rd_word ({rbuf, off}),
    .rd_data (mem_q)
  );

  // read path, one cycle latency
  rd_kind_e    rd_kind_q;
  logic [31:0] reg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_kind_q <= RD_ZERO;
      reg_q     <= '0;
    end else begin
      if (is_rx)       rd_kind_q <= is_ctrl ? RD_REG : RD_MEM;
      else if (is_gie) rd_kind_q <= RD_REG;
      else             rd_kind_q <= RD_ZERO;
      reg_q <= is_gie ? gie : ctrl[rbuf];
    end
  end

  always_comb begin
    case (rd_kind_q)
      RD_REG:  bus_rdata = reg_q;
      RD_MEM:  bus_rdata = mem_q;
      default: bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/ethrx_pingpong_chk.sv
module ethrx_pingpong_chk #(
  parameter int unsigned CAP_BYTES = 2044,
  parameter int unsigned CW        = 11,
  parameter bit          PINGPONG  = 1'b1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_valid,
  input logic          rx_irq,
  input logic          ev_commit,
  input logic          ev_reject,
  input logic          drop_now,
  input logic          ev_wr,
  input logic [CW-1:0] wr_idx,
  input logic          sel,
  input logic [1:0]    s_bits
);

  p_irq_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |=> !rx_irq);

  p_irq_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> $past(ev_commit));

  p_commit_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_commit |=> s_bits[$past(sel)]);

  p_drop_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && drop_now) |-> !ev_wr);

  p_cap_limit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr |-> (wr_idx < CW'(CAP_BYTES)));

  p_sel_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_commit |=> $stable(sel));

  p_reject_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_reject |=> !rx_irq);

  if (PINGPONG) begin : g_toggle
    p_sel_toggle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ev_commit |=> (sel != $past(sel)));
  end

endmodule

bind ethrx_pingpong ethrx_pingpong_chk #(
  .CAP_BYTES (CAP),
  .CW        (CW),
  .PINGPONG  (PINGPONG)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rx_valid  (rx_valid),
  .rx_irq    (rx_irq),
  .ev_commit (ev_commit),
  .ev_reject (ev_reject),
  .drop_now  (drop_now),
  .ev_wr     (ev_wr),
  .wr_idx    (wr_idx),
  .sel       (sel),
  .s_bits    (s_bits)
);

// File: tb/ethrx_pingpong_tb.sv
module ethrx_pingpong_tb;

  localparam int CLK_PERIOD = 10;
  localparam int BB  = 64;
  localparam int W   = BB / 4;
  localparam int CAP = BB - 4;
  localparam int AW  = $clog2(BB);
  localparam logic [47:0] STATION = 48'h02_11_22_33_44_55;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          rx_valid, rx_last;
  logic [7:0]    rx_data;
  logic [AW-1:0] bus_addr;
  logic          bus_wen;
  logic [31:0]   bus_wdata;
  logic [31:0]   rdata_pp, rdata_sg;
  logic          irq_pp, irq_sg;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;
  int exp_sel = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ethrx_pingpong #(.BUF_BYTES(BB), .PINGPONG(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_last(rx_last), .station_mac(STATION), .bus_addr(bus_addr),
    .bus_wen(bus_wen), .bus_wdata(bus_wdata), .bus_rdata(rdata_pp), .rx_irq(irq_pp));

  ethrx_pingpong #(.BUF_BYTES(BB), .PINGPONG(1'b0)) u_single (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_last(rx_last), .station_mac(STATION), .bus_addr(bus_addr),
    .bus_wen(bus_wen), .bus_wdata(bus_wdata), .bus_rdata(rdata_sg), .rx_irq(irq_sg));

  function automatic logic [AW-1:0] ctrl_addr(input int b);
    return AW'(2 * W + b * W + W - 1);
  endfunction

  function automatic logic [AW-1:0] data_addr(input int b, input int w);
    return AW'(2 * W + b * W + w);
  endfunction

  function automatic logic [7:0] fbyte(input int seed, input int k, input logic [47:0] da);
    if (k < 6) return da[8 * (5 - k) +: 8];
    return 8'(seed * 7 + k * 13 + 1);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; rx_valid = 1'b0; rx_last = 1'b0; rx_data = '0;
    bus_addr = '0; bus_wen = 1'b0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    exp_sel = 0;
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wen = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wen = 1'b0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] pp, output logic [31:0] sg);
    @(negedge clk);
    bus_addr = a; bus_wen = 1'b0;
    @(negedge clk);
    pp = rdata_pp; sg = rdata_sg;
  endtask

  task automatic send_frame(input int len, input logic [47:0] da, input int seed,
                            input bit coll, input logic [AW-1:0] ca, input logic [31:0] cd,
                            output bit ipp, output bit isg, output bit after);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_data = fbyte(seed, k, da); rx_last = (k == len - 1);
      if (coll && k == len - 1) begin
        bus_addr = ca; bus_wen = 1'b1; bus_wdata = cd;
      end
    end
    @(negedge clk);
    ipp = irq_pp; isg = irq_sg;
    rx_valid = 1'b0; rx_last = 1'b0; bus_wen = 1'b0;
    @(negedge clk);
    after = irq_pp | irq_sg;
  endtask

  task automatic check_buf(input bit single, input int b, input int len,
                           input logic [47:0] da, input int seed, input string req);
    int bad = 0;
    logic [31:0] ga = '0, ea = '0;
    logic [31:0] pp, sg, got, exp, mask;
    int stored = (len < CAP) ? len : CAP;
    for (int w = 0; w < W - 1; w++) begin
      exp = '0; mask = '0;
      for (int j = 0; j < 4; j++) begin
        if (4 * w + j < stored) begin
          exp[31 - 8 * j -: 8]  = fbyte(seed, 4 * w + j, da);
          mask[31 - 8 * j -: 8] = 8'hFF;
        end
      end
      if (mask != '0) begin
        bus_read(data_addr(b, w), pp, sg);
        got = single ? sg : pp;
        if (((got ^ exp) & mask) != '0) begin
          if (bad == 0) begin ga = got & mask; ea = exp; end
          bad++;
        end
      end
    end
    check(bad == 0, req, $sformatf("buffer %0d contents len %0d", b, len), ga, ea);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL timeout watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] pp, sg;
    bit ipp, isg, aft;
    logic [47:0] da;

    do_reset();

    // R11: reset state
    check(irq_pp == 1'b0 && irq_sg == 1'b0, "R11", "irq after reset", {31'd0, irq_pp}, 32'd0);
    bus_read(ctrl_addr(0), pp, sg);
    check(pp == 32'd0, "R11", "ctrl0 after reset", pp, 32'd0);
    bus_read(ctrl_addr(1), pp, sg);
    check(pp == 32'd0, "R11", "ctrl1 after reset", pp, 32'd0);
    bus_read(AW'(W - 2), pp, sg);
    check(pp == 32'd0, "R11", "gie after reset", pp, 32'd0);

    // R1 / R10: register access
    bus_write(AW'(W - 2), 32'h8000_0000);
    bus_write(AW'(3), 32'hDEAD_BEEF);
    bus_read(AW'(3), pp, sg);
    check(pp == 32'd0, "R1", "unmapped lower word", pp, 32'd0);
    bus_read(AW'(W - 2), pp, sg);
    check(pp == 32'h8000_0000, "R1", "gie readback", pp, 32'h8000_0000);
    bus_write(ctrl_addr(1), 32'h1234_5678);
    bus_read(ctrl_addr(1), pp, sg);
    check(pp == 32'h1234_5678, "R10", "ctrl1 stored as written", pp, 32'h1234_5678);
    bus_write(ctrl_addr(0), 32'h8);
    bus_write(ctrl_addr(1), 32'h8);

    // R2/R5/R6/R7: unicast match into buffer 0
    send_frame(20, STATION, 1, 1'b0, '0, '0, ipp, isg, aft);
    check(ipp == 1'b1, "R7", "irq on stored frame", {31'd0, ipp}, 32'd1);
    check(aft == 1'b0, "R7", "irq lasts one cycle", {31'd0, aft}, 32'd0);
    bus_read(ctrl_addr(0), pp, sg);
    check(pp == 32'h9, "R6", "ctrl0 full", pp, 32'h9);
    check_buf(1'b0, 0, 20, STATION, 1, "R5");

    // R8: second frame goes to buffer 1
    send_frame(13, STATION, 2, 1'b0, '0, '0, ipp, isg, aft);
    bus_read(ctrl_addr(1), pp, sg);
    check(pp == 32'h9, "R8", "ctrl1 full after second frame", pp, 32'h9);
    check_buf(1'b0, 1, 13, STATION, 2, "R8");

    // R4: buffer 0 full, frame dropped
    send_frame(16, STATION, 3, 1'b0, '0, '0, ipp, isg, aft);
    check(ipp == 1'b0, "R4", "no irq on drop", {31'd0, ipp}, 32'd0);
    check_buf(1'b0, 0, 20, STATION, 1, "R4");

    // R10 release, then R2 mismatch at each address byte
    bus_write(ctrl_addr(0), 32'h8);
    bus_read(ctrl_addr(0), pp, sg);
    check(pp == 32'h8, "R10", "ctrl0 released", pp, 32'h8);
    for (int p = 0; p < 6; p++) begin
      da = STATION ^ (48'h01 << (8 * (5 - p)));
      send_frame(20, da, 10 + p, 1'b0, '0, '0, ipp, isg, aft);
      check(ipp == 1'b0, "R2", $sformatf("no irq mismatch byte %0d", p), {31'd0, ipp}, 32'd0);
      bus_read(ctrl_addr(0), pp, sg);
      check(pp == 32'h8, "R2", $sformatf("ctrl0 unchanged mismatch byte %0d", p), pp, 32'h8);
    end

    // R3: short frames, matching prefix and group
    for (int l = 1; l < 6; l++) begin
      send_frame(l, STATION, 20 + l, 1'b0, '0, '0, ipp, isg, aft);
      send_frame(l, 48'hFF_FF_FF_FF_FF_FF, 30 + l, 1'b0, '0, '0, ipp, isg, aft);
      bus_read(ctrl_addr(0), pp, sg);
      check(pp == 32'h8, "R3", $sformatf("short frame len %0d ignored", l), pp, 32'h8);
    end

    // R9 + R2 group bypass: long group frame into buffer 0 (pointer unchanged)
    send_frame(CAP + 10, 48'h81_00_00_00_00_00, 4, 1'b0, '0, '0, ipp, isg, aft);
    check(ipp == 1'b1, "R2", "group frame accepted", {31'd0, ipp}, 32'd1);
    bus_read(ctrl_addr(0), pp, sg);
    check(pp == 32'h9, "R9", "ctrl0 intact and full", pp, 32'h9);
    check_buf(1'b0, 0, CAP + 10, 48'h81_00_00_00_00_00, 4, "R9");
    exp_sel = 1;

    // R7: I bit clear -> no irq
    bus_write(ctrl_addr(1), 32'h0);
    send_frame(8, STATION, 5, 1'b0, '0, '0, ipp, isg, aft);
    check(ipp == 1'b0, "R7", "no irq when I clear", {31'd0, ipp}, 32'd0);
    bus_read(ctrl_addr(1), pp, sg);
    check(pp == 32'h1, "R6", "ctrl1 full without I", pp, 32'h1);

    // R7: global enable clear -> no irq
    bus_write(AW'(W - 2), 32'h0);
    bus_write(ctrl_addr(0), 32'h8);
    send_frame(10, STATION, 6, 1'b0, '0, '0, ipp, isg, aft);
    check(ipp == 1'b0, "R7", "no irq when gie clear", {31'd0, ipp}, 32'd0);
    bus_read(ctrl_addr(0), pp, sg);
    check(pp == 32'h9, "R6", "ctrl0 full with gie clear", pp, 32'h9);
    bus_write(AW'(W - 2), 32'h8000_0000);

    // R10: software write colliding with completion into buffer 1
    bus_write(ctrl_addr(1), 32'h8);
    send_frame(12, STATION, 7, 1'b1, ctrl_addr(1), 32'h40, ipp, isg, aft);
    bus_read(ctrl_addr(1), pp, sg);
    check(pp == 32'h41, "R10", "collision keeps S", pp, 32'h41);
    exp_sel = 0;

    // R5/R8 sweep over every length around the limit
    for (int l = 6; l <= CAP + 4; l++) begin
      da = l[0] ? 48'hA3_01_02_03_04_05 : STATION;
      bus_write(ctrl_addr(0), 32'h8);
      bus_write(ctrl_addr(1), 32'h8);
      send_frame(l, da, 100 + l, 1'b0, '0, '0, ipp, isg, aft);
      check(ipp == 1'b1, "R7", $sformatf("irq sweep len %0d", l), {31'd0, ipp}, 32'd1);
      bus_read(ctrl_addr(exp_sel), pp, sg);
      check(pp == 32'h9, "R8", $sformatf("target buffer %0d full len %0d", exp_sel, l), pp, 32'h9);
      check_buf(1'b0, exp_sel, l, da, 100 + l, "R5");
      exp_sel ^= 1;
    end

    // R8: single-buffer variant
    do_reset();
    bus_write(AW'(W - 2), 32'h8000_0000);
    bus_write(ctrl_addr(0), 32'h8);
    send_frame(9, STATION, 40, 1'b0, '0, '0, ipp, isg, aft);
    check(isg == 1'b1, "R8", "single irq first frame", {31'd0, isg}, 32'd1);
    send_frame(9, STATION, 41, 1'b0, '0, '0, ipp, isg, aft);
    check(isg == 1'b0, "R8", "single drops when buffer 0 full", {31'd0, isg}, 32'd0);
    bus_read(ctrl_addr(1), pp, sg);
    check(sg == 32'h0, "R8", "single never uses buffer 1", sg, 32'h0);
    bus_write(ctrl_addr(0), 32'h8);
    send_frame(11, STATION, 42, 1'b0, '0, '0, ipp, isg, aft);
    bus_read(ctrl_addr(0), pp, sg);
    check(sg == 32'h9, "R8", "single refills buffer 0", sg, 32'h9);
    check_buf(1'b1, 0, 11, STATION, 42, "R8");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule